// File: doc/BRIEF.md
# Dual-Port Radio Frame Buffer

This block is a byte-wide frame store that two independent agents share. The baseband side streams a received frame into the store, or streams a stored frame out for transmission. The host side reaches the same bytes through the serial-interface logic, either one byte at a time through its own auto-incrementing pointer or by direct address. Byte 0 of the store is the frame length. The payload, including its two checksum bytes, follows at addresses 1 to L.

During reception the baseband side also hands over three quality bytes. When the host drains a frame sequentially, these bytes follow the last payload byte. On transmission the block can replace the last two payload bytes with a checksum that it receives on an input. The host therefore does not need to write them.

Two protections keep concurrent use safe. A sticky flag reports when the host pointer catches up with the baseband pointer during an active transfer. After sleep or reset, a contents-invalid flag forces every read to zero until new data is written.

Top module: `frame_store`

## Requirements
- R1: After reset or a `sleep_i` pulse, `invalid_o` is 1 and every read on either port returns 0x00. Any accepted write on either port clears `invalid_o` on the next edge. If a sleep pulse and a write arrive in the same cycle, the sleep wins.
- R2: When `host_rand_i` is 1, a host write stores `host_wdata_i` at `host_addr_i`, and a host read returns the byte at `host_addr_i` on `host_rdata_o` one edge later. Random accesses leave the host pointer unchanged.
- R3: `host_start_i` sets the host pointer P to 0. Each sequential host read then returns the following sequence, and P advances by one after each read:
  - stored bytes 0 to L, where L is the length byte at address 0;
  - the latched link-quality byte;
  - the energy byte;
  - the status byte.
- R4: A sequential host read with P above L+3 returns 0x00 and leaves P unchanged. A later sequential host write lands at address L+4.
- R5: `bb_start_i` sets the baseband pointer B to 0 and marks a transfer as active. Each `bb_wr_i` stores a byte at B, and each `bb_rd_i` returns the byte at B on `bb_rdata_o` one edge later. B advances by one after either access. `bb_done_i` ends the transfer.
- R6: Auto-checksum applies when `auto_crc_i` is 1 and L ≥ 2. In that case a baseband read at address L-1 returns `crc_i[7:0]`, and a baseband read at address L returns `crc_i[15:8]`. Otherwise, including a one-byte frame (L = 1), the stored bytes are returned.
- R7: While a baseband transfer is active, a sequential host access with P ≥ B sets `viol_o`. While no transfer is active, `viol_o` is never set.
- R8: `viol_o` stays set until a `viol_clr_i` pulse clears it. If a new violation arrives in the same cycle as the clear, the flag stays set.
- R9: If both ports write the same address in the same cycle, the baseband byte is the one that is kept.
- R10: A length byte above DEPTH-1 (127) is treated as 127 when the block builds the host read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | Sleep entry pulse; marks contents invalid |
| bb_start_i | input | 1 | Start baseband transfer, pointer to 0 |
| bb_done_i | input | 1 | End baseband transfer |
| bb_wr_i | input | 1 | Baseband write at its pointer |
| bb_rd_i | input | 1 | Baseband read at its pointer |
| bb_wdata_i | input | 8 | Baseband write byte |
| bb_rdata_o | output | 8 | Baseband read byte (one edge after request) |
| rx_meta_we_i | input | 1 | Latch the three receive quality bytes |
| rx_lqi_i | input | 8 | Link-quality byte |
| rx_ed_i | input | 8 | Energy byte |
| rx_stat_i | input | 8 | Receive status byte |
| auto_crc_i | input | 1 | Substitute checksum on baseband reads |
| crc_i | input | 16 | Computed checksum, low byte first in frame |
| host_start_i | input | 1 | Host pointer to 0 |
| host_rand_i | input | 1 | Host access uses `host_addr_i` |
| host_addr_i | input | 7 | Host random address |
| host_wr_i | input | 1 | Host write |
| host_rd_i | input | 1 | Host read |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte (one edge after request) |
| viol_clr_i | input | 1 | Clear the violation flag |
| viol_o | output | 1 | Sticky access violation |
| invalid_o | output | 1 | Contents invalid since sleep or reset |

## Verification
Timing of each result:
- Both read paths are a single register, so the data for a read is valid after the first rising edge that follows the request.
- The invalid flag and the violation flag are also single registers, so each reacts on the first edge after the event that sets or clears it.
- Pointer movement shows up at the next access. For this reason, the R4 check writes after the overrun reads and then looks for that byte at address L+4.

How the bench keeps to that timing:
- It drives every input just after a falling edge.
- It holds each input through exactly one rising edge.
- It samples at the next falling edge, which is the cycle in which every result is due.

// File: rtl/fbuf_pkg.sv
// Shared definitions for the frame buffer.
// Assumes byte-wide storage; the host read source is decoded into an enum.
package fbuf_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Where a host read takes its byte from
    typedef enum logic [2:0] {
        SRC_MEM  = 3'd0,
        SRC_LQI  = 3'd1,
        SRC_ED   = 3'd2,
        SRC_STAT = 3'd3,
        SRC_ZERO = 3'd4
    } hsrc_e;
endpackage

// File: rtl/fbuf_cnt.sv
// Port address pointer: cleared by clr, advanced by inc.
// Assumes the caller gates inc with any limit; clr has priority over inc.
module fbuf_cnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Pointer register update
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/fbuf_mem.sv
// Flop-array byte store with two write ports and two combinational read ports.
// Port A (baseband) wins over port B (host) on the same address.
// Assumes no reset of contents; validity is tracked outside.
module fbuf_mem
    import fbuf_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_a,
    input  logic [AW-1:0] addr_a,
    input  byte_t         din_a,
    input  logic          we_b,
    input  logic [AW-1:0] addr_b,
    input  byte_t         din_b,
    input  logic [AW-1:0] raddr_a,
    output byte_t         rdata_a,
    input  logic [AW-1:0] raddr_b,
    output byte_t         rdata_b,
    output byte_t         len_byte
);
    byte_t cells [DEPTH];

    // Writes: host first, baseband last so it overrides a collision
    always_ff @(posedge clk) begin
        if (we_b) cells[addr_b] <= din_b;
        if (we_a) cells[addr_a] <= din_a;
    end

    // Combinational read ports and the length byte at address 0
    always_comb begin
        rdata_a  = cells[raddr_a];
        rdata_b  = cells[raddr_b];
        len_byte = cells[0];
    end
endmodule

// File: rtl/fbuf_flags.sv
// Control flags: contents-invalid, baseband-transfer-active and sticky violation.
// Assumes single-cycle pulses on sleep, start, done and clear.
module fbuf_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic any_we,
    input  logic bb_start,
    input  logic bb_done,
    input  logic viol_set,
    input  logic viol_clr,
    output logic invalid,
    output logic bb_active,
    output logic viol
);
    // Invalid after reset or sleep, cleared by any write; sleep wins
    always_ff @(posedge clk) begin
        if (!rst_n)      invalid <= 1'b1;
        else if (sleep)  invalid <= 1'b1;
        else if (any_we) invalid <= 1'b0;
    end

    // Baseband transfer window
    always_ff @(posedge clk) begin
        if (!rst_n)        bb_active <= 1'b0;
        else if (sleep)    bb_active <= 1'b0;
        else if (bb_start) bb_active <= 1'b1;
        else if (bb_done)  bb_active <= 1'b0;
    end

    // Sticky violation; a new violation beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n)        viol <= 1'b0;
        else if (viol_set) viol <= 1'b1;
        else if (viol_clr) viol <= 1'b0;
    end
endmodule

// File: rtl/frame_store.sv
// Dual-port radio frame buffer top.
// Baseband and host each own a pointer into a shared byte store. The host
// sequential read appends the receive quality bytes after the frame. Baseband
// reads can substitute a supplied checksum for the last two payload bytes.
// Assumes the byte at address 0 is the frame length; reads are registered.
module frame_store
    import fbuf_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep_i,
    input  logic                      bb_start_i,
    input  logic                      bb_done_i,
    input  logic                      bb_wr_i,
    input  logic                      bb_rd_i,
    input  logic [7:0]                bb_wdata_i,
    output logic [7:0]                bb_rdata_o,
    input  logic                      rx_meta_we_i,
    input  logic [7:0]                rx_lqi_i,
    input  logic [7:0]                rx_ed_i,
    input  logic [7:0]                rx_stat_i,
    input  logic                      auto_crc_i,
    input  logic [15:0]               crc_i,
    input  logic                      host_start_i,
    input  logic                      host_rand_i,
    input  logic [$clog2(DEPTH)-1:0]  host_addr_i,
    input  logic                      host_wr_i,
    input  logic                      host_rd_i,
    input  logic [7:0]                host_wdata_i,
    output logic [7:0]                host_rdata_o,
    input  logic                      viol_clr_i,
    output logic                      viol_o,
    output logic                      invalid_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 2;               // room for L+4
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    logic [CW-1:0] bb_cnt, host_cnt, frame_len, len_p1, len_p2, len_p3;
    byte_t         len_byte, mem_bb, mem_host;
    byte_t         lqi_q, ed_q, stat_q;
    logic          host_seq_rd, host_seq_wr, host_we, host_inc, bb_inc;
    logic          viol_set, any_we, bb_active;
    logic [AW-1:0] host_ptr_addr;
    hsrc_e         host_src;

    // Length decode with clamp to the last cell
    always_comb begin
        frame_len = (CW'(len_byte) > LAST) ? LAST : CW'(len_byte);
        len_p1    = frame_len + CW'(1);
        len_p2    = frame_len + CW'(2);
        len_p3    = frame_len + CW'(3);
    end

    // Host access decode: address, write enable, pointer advance
    always_comb begin
        host_seq_rd   = host_rd_i && !host_rand_i;
        host_seq_wr   = host_wr_i && !host_rand_i;
        host_ptr_addr = host_rand_i ? host_addr_i : host_cnt[AW-1:0];
        host_we       = host_rand_i ? host_wr_i
                                    : (host_seq_wr && (host_cnt < CW'(DEPTH)));
        host_inc      = host_seq_wr ? (host_cnt < LAST)
                                    : (host_seq_rd && (host_cnt <= len_p3));
        bb_inc        = (bb_wr_i || bb_rd_i) && (bb_cnt < LAST);
        any_we        = bb_wr_i || host_we;
        viol_set      = bb_active && (host_seq_rd || host_seq_wr)
                        && (host_cnt >= bb_cnt);
    end

    fbuf_cnt #(.W(CW)) u_bb_cnt (
        .clk(clk), .rst_n(rst_n), .clr(bb_start_i), .inc(bb_inc), .cnt(bb_cnt)
    );

    fbuf_cnt #(.W(CW)) u_host_cnt (
        .clk(clk), .rst_n(rst_n), .clr(host_start_i), .inc(host_inc), .cnt(host_cnt)
    );

    fbuf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk),
        .we_a(bb_wr_i), .addr_a(bb_cnt[AW-1:0]), .din_a(bb_wdata_i),
        .we_b(host_we), .addr_b(host_ptr_addr), .din_b(host_wdata_i),
        .raddr_a(bb_cnt[AW-1:0]), .rdata_a(mem_bb),
        .raddr_b(host_ptr_addr), .rdata_b(mem_host),
        .len_byte(len_byte)
    );

    fbuf_flags u_flags (
        .clk(clk), .rst_n(rst_n), .sleep(sleep_i), .any_we(any_we),
        .bb_start(bb_start_i), .bb_done(bb_done_i),
        .viol_set(viol_set), .viol_clr(viol_clr_i),
        .invalid(invalid_o), .bb_active(bb_active), .viol(viol_o)
    );

    // Latch receive quality bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lqi_q  <= '0;
            ed_q   <= '0;
            stat_q <= '0;
        end else if (rx_meta_we_i) begin
            lqi_q  <= rx_lqi_i;
            ed_q   <= rx_ed_i;
            stat_q <= rx_stat_i;
        end
    end

    // Select the source of a host read
    always_comb begin
        if (invalid_o)                host_src = SRC_ZERO;
        else if (host_rand_i)         host_src = SRC_MEM;
        else if (host_cnt <= frame_len) host_src = SRC_MEM;
        else if (host_cnt == len_p1)  host_src = SRC_LQI;
        else if (host_cnt == len_p2)  host_src = SRC_ED;
        else if (host_cnt == len_p3)  host_src = SRC_STAT;
        else                          host_src = SRC_ZERO;
    end

    // Register host read data
    always_ff @(posedge clk) begin
        if (!rst_n) host_rdata_o <= '0;
        else if (host_rd_i) begin
            case (host_src)
                SRC_MEM:  host_rdata_o <= mem_host;
                SRC_LQI:  host_rdata_o <= lqi_q;
                SRC_ED:   host_rdata_o <= ed_q;
                SRC_STAT: host_rdata_o <= stat_q;
                default:  host_rdata_o <= '0;
            endcase
        end
    end

    // Register baseband read data with optional checksum substitution
    always_ff @(posedge clk) begin
        if (!rst_n) bb_rdata_o <= '0;
        else if (bb_rd_i) begin
            if (invalid_o)
                bb_rdata_o <= '0;
            else if (auto_crc_i && (frame_len >= CW'(2)) && (bb_cnt == frame_len - CW'(1)))
                bb_rdata_o <= crc_i[7:0];
            else if (auto_crc_i && (frame_len >= CW'(2)) && (bb_cnt == frame_len))
                bb_rdata_o <= crc_i[15:8];
            else
                bb_rdata_o <= mem_bb;
        end
    end
endmodule

// File: rtl/frame_store_chk.sv
// Property checker for frame_store, attached by bind.
// Assumes it sees the top's ports plus its pointer, length and transfer flag.
module frame_store_chk #(
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_i,
    input logic          bb_wr_i,
    input logic          host_rd_i,
    input logic          host_rand_i,
    input logic          host_start_i,
    input logic          viol_clr_i,
    input logic          viol_o,
    input logic          invalid_o,
    input logic [7:0]    host_rdata_o,
    input logic          bb_active,
    input logic [CW-1:0] host_cnt,
    input logic [CW-1:0] frame_len
);
    AST_SLEEP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> invalid_o); // R1
    AST_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_wr_i && !sleep_i) |=> !invalid_o); // R1
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_o && host_rd_i) |=> (host_rdata_o == 8'h00)); // R1
    AST_OVERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && !host_rand_i && (host_cnt > frame_len + CW'(3)))
        |=> (host_rdata_o == 8'h00)); // R4
    AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && !host_rand_i && !host_start_i
         && (host_cnt > frame_len + CW'(3))) |=> $stable(host_cnt)); // R4
    AST_IDLE_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        (!bb_active && !viol_o) |=> !viol_o); // R7
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_o && !viol_clr_i) |=> viol_o); // R8
endmodule

bind frame_store frame_store_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .bb_wr_i(bb_wr_i),
    .host_rd_i(host_rd_i), .host_rand_i(host_rand_i), .host_start_i(host_start_i),
    .viol_clr_i(viol_clr_i), .viol_o(viol_o), .invalid_o(invalid_o),
    .host_rdata_o(host_rdata_o), .bb_active(bb_active),
    .host_cnt(host_cnt), .frame_len(frame_len)
);

// File: tb/sim_frame_store.sv
`timescale 1ns/1ps
module sim_frame_store;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_i = 0, bb_start_i = 0, bb_done_i = 0, bb_wr_i = 0, bb_rd_i = 0;
    logic [7:0] bb_wdata_i = 0, bb_rdata_o;
    logic rx_meta_we_i = 0;
    logic [7:0] rx_lqi_i = 0, rx_ed_i = 0, rx_stat_i = 0;
    logic auto_crc_i = 0;
    logic [15:0] crc_i = 0;
    logic host_start_i = 0, host_rand_i = 0, host_wr_i = 0, host_rd_i = 0;
    logic [6:0] host_addr_i = 0;
    logic [7:0] host_wdata_i = 0, host_rdata_o;
    logic viol_clr_i = 0, viol_o, invalid_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] d;

    always #2.5 clk = ~clk;

    frame_store u0 (.*);

    // {is_read, addr, wdata, expected}
    localparam logic [23:0] VEC [8] = '{
        {1'b0, 7'd10,  8'h3C, 8'h00},
        {1'b0, 7'd11,  8'hC3, 8'h00},
        {1'b0, 7'd127, 8'h5A, 8'h00},
        {1'b1, 7'd10,  8'h00, 8'h3C},
        {1'b1, 7'd11,  8'h00, 8'hC3},
        {1'b1, 7'd127, 8'h00, 8'h5A},
        {1'b0, 7'd10,  8'h00, 8'h00},
        {1'b1, 7'd10,  8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic hwr_rand(input logic [6:0] a, input logic [7:0] v);
        @(negedge clk); host_rand_i = 1; host_wr_i = 1; host_addr_i = a; host_wdata_i = v;
        @(negedge clk); host_rand_i = 0; host_wr_i = 0;
    endtask

    task automatic hrd_rand(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk); host_rand_i = 1; host_rd_i = 1; host_addr_i = a;
        @(negedge clk); host_rand_i = 0; host_rd_i = 0; v = host_rdata_o;
    endtask

    task automatic hrd_seq(output logic [7:0] v);
        @(negedge clk); host_rd_i = 1;
        @(negedge clk); host_rd_i = 0; v = host_rdata_o;
    endtask

    task automatic hwr_seq(input logic [7:0] v);
        @(negedge clk); host_wr_i = 1; host_wdata_i = v;
        @(negedge clk); host_wr_i = 0;
    endtask

    task automatic host_start();
        @(negedge clk); host_start_i = 1;
        @(negedge clk); host_start_i = 0;
    endtask

    task automatic bb_start();
        @(negedge clk); bb_start_i = 1;
        @(negedge clk); bb_start_i = 0;
    endtask

    task automatic bb_done();
        @(negedge clk); bb_done_i = 1;
        @(negedge clk); bb_done_i = 0;
    endtask

    task automatic bb_wr(input logic [7:0] v);
        @(negedge clk); bb_wr_i = 1; bb_wdata_i = v;
        @(negedge clk); bb_wr_i = 0;
    endtask

    task automatic bb_rd(output logic [7:0] v);
        @(negedge clk); bb_rd_i = 1;
        @(negedge clk); bb_rd_i = 0; v = bb_rdata_o;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        @(negedge clk);
        chk("R1 invalid after reset", {7'd0, invalid_o}, 8'h01);
        chk("R8 viol clear after reset", {7'd0, viol_o}, 8'h00);
        hrd_rand(7'd10, d);
        chk("R1 read zero while invalid", d, 8'h00);

        // R2: vector table of random host accesses
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][23]) begin
                hrd_rand(VEC[i][22:16], d);
                chk("R2 random read", d, VEC[i][7:0]);
            end else begin
                hwr_rand(VEC[i][22:16], VEC[i][15:8]);
            end
        end
        chk("R1 write clears invalid", {7'd0, invalid_o}, 8'h00);

        // R5: baseband writes a 4-byte frame, quality bytes latched
        bb_start();
        bb_wr(8'h04); bb_wr(8'hA1); bb_wr(8'hA2); bb_wr(8'hA3); bb_wr(8'hA4);
        @(negedge clk); rx_meta_we_i = 1; rx_lqi_i = 8'h11; rx_ed_i = 8'h22; rx_stat_i = 8'h33;
        @(negedge clk); rx_meta_we_i = 0;
        bb_done();

        // R3: sequential host read: frame then quality bytes
        host_start();
        hrd_seq(d); chk("R3 length byte", d, 8'h04);
        hrd_seq(d); chk("R3 payload 1", d, 8'hA1);
        hrd_seq(d); chk("R3 payload 2", d, 8'hA2);
        hrd_seq(d); chk("R3 payload 3", d, 8'hA3);
        hrd_seq(d); chk("R3 payload 4", d, 8'hA4);
        hrd_seq(d); chk("R3 lqi", d, 8'h11);
        hrd_seq(d); chk("R3 energy", d, 8'h22);
        hrd_seq(d); chk("R3 status", d, 8'h33);
        // R4: overrun returns zero and pointer holds at L+4 = 8
        hrd_seq(d); chk("R4 overrun zero", d, 8'h00);
        hrd_seq(d); chk("R4 overrun zero again", d, 8'h00);
        hwr_seq(8'h77);
        hrd_rand(7'd8, d); chk("R4 pointer held at L+4", d, 8'h77);

        // R5/R6: baseband readout with checksum substitution
        crc_i = 16'hBEEF; auto_crc_i = 1;
        bb_start();
        bb_rd(d); chk("R5 bb read length", d, 8'h04);
        bb_rd(d); chk("R5 bb read payload", d, 8'hA1);
        bb_rd(d); chk("R6 stored byte before checksum", d, 8'hA2);
        bb_rd(d); chk("R6 crc low at L-1", d, 8'hEF);
        bb_rd(d); chk("R6 crc high at L", d, 8'hBE);
        auto_crc_i = 0;
        bb_start();
        bb_rd(d); bb_rd(d); bb_rd(d); bb_rd(d);
        chk("R6 no substitution when disabled", d, 8'hA3);
        bb_done();

        // R6: one-byte frame keeps its stored data byte
        hwr_rand(7'd0, 8'h01); hwr_rand(7'd1, 8'h99);
        auto_crc_i = 1;
        bb_start();
        bb_rd(d); chk("R6 minimum frame length", d, 8'h01);
        bb_rd(d); chk("R6 minimum frame data kept", d, 8'h99);
        bb_done();
        auto_crc_i = 0;

        // R7/R8: host pointer catching baseband pointer
        bb_start();
        bb_wr(8'h05); bb_wr(8'hB1);
        host_start();
        hrd_seq(d); hrd_seq(d);
        chk("R7 no violation while behind", {7'd0, viol_o}, 8'h00);
        hrd_seq(d);
        chk("R7 violation when caught up", {7'd0, viol_o}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R8 violation sticky", {7'd0, viol_o}, 8'h01);
        @(negedge clk); viol_clr_i = 1;
        @(negedge clk); viol_clr_i = 0;
        chk("R8 violation cleared", {7'd0, viol_o}, 8'h00);
        bb_done();
        host_start();
        hrd_seq(d); hrd_seq(d); hrd_seq(d);
        chk("R7 no violation when idle", {7'd0, viol_o}, 8'h00);

        // R9: same-address collision, baseband wins
        bb_start();
        @(negedge clk);
        bb_wr_i = 1; bb_wdata_i = 8'hAA;
        host_rand_i = 1; host_wr_i = 1; host_addr_i = 7'd0; host_wdata_i = 8'h55;
        @(negedge clk);
        bb_wr_i = 0; host_rand_i = 0; host_wr_i = 0;
        bb_done();
        hrd_rand(7'd0, d); chk("R9 baseband wins collision", d, 8'hAA);

        // R10: oversize length clamps to 127
        hwr_rand(7'd0, 8'hC8);
        host_start();
        for (int i = 0; i < 128; i++) hrd_seq(d);
        hrd_seq(d); chk("R10 lqi after clamped length", d, 8'h11);
        hrd_seq(d); chk("R10 energy after clamped length", d, 8'h22);
        hrd_seq(d); chk("R10 status after clamped length", d, 8'h33);
        hrd_seq(d); chk("R10 zero past clamped frame", d, 8'h00);

        // R1: sleep invalidates, a write revalidates
        @(negedge clk); sleep_i = 1;
        @(negedge clk); sleep_i = 0;
        chk("R1 invalid after sleep", {7'd0, invalid_o}, 8'h01);
        hrd_rand(7'd10, d); chk("R1 read zero after sleep", d, 8'h00);
        bb_start();
        bb_rd(d); chk("R1 bb read zero after sleep", d, 8'h00);
        bb_done();
        hwr_rand(7'd20, 8'h42);
        chk("R1 write after sleep clears invalid", {7'd0, invalid_o}, 8'h00);
        hrd_rand(7'd20, d); chk("R2 read after revalidate", d, 8'h42);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule